// File: doc/BRIEF.md
# Dual-Bank Associative Road Finder

This block is the pattern-recognition stage of a two-step hardware tracker. It holds a bank of track patterns, each one a list of coarse position bins (superstrips), one per logical detector layer. A stream of hits, one per clock, is compared in parallel against every pattern. Each pattern keeps one match flag per layer, and a pattern whose flags are all set becomes a road: a low-resolution track candidate for a later fitting stage.

Two copies of the bank run side by side. The first bins a hit's fine position into superstrips directly. The second uses bin edges moved by half a superstrip, so a hit falls into the same bin number or the one below, depending on the fine-position bit just under the superstrip field. A road is reported only when both copies match at the same pattern address. This gives roughly half-bin resolution without doubling the pattern count. After an end-of-event strobe, the surviving roads are streamed out in ascending address order over a valid/ready port. All flags are then cleared and the block accepts the next event. Patterns are written through a plain write port, one layer entry per cycle.

Top module: `am_road_finder`

## Requirements
- R1: A write with `ld_en` high stores `ld_ss` as the superstrip of layer `ld_layer` of pattern `ld_addr` in the bank chosen by `ld_bank` (0 = direct bins, 1 = half-bin shifted). Later hits are compared against the new value.
- R2: In the direct bank, a hit's superstrip is `hit_pos` shifted right by `SS_SHIFT` bits, so a superstrip spans 2^SS_SHIFT fine units. An accepted hit on layer L sets layer flag L of every pattern whose stored layer-L superstrip equals it. Flags change only on accepted hits and on the end-of-event clear.
- R3: In the shifted bank, when bit `SS_SHIFT-1` of `hit_pos` is 1 the superstrip equals the direct one. When that bit is 0 it is one less. A hit with direct superstrip 0 and that bit 0 matches nothing in the shifted bank.
- R4: A pattern address is a road only when it is matched in both banks. A match in one bank alone gives no road.
- R5: A pattern is matched in a bank when at least `N_LAYERS - MISS_ALLOW` of its layer flags are set (default `MISS_ALLOW` = 0, so every layer is required). A pattern with one layer missing gives no road by default.
- R6: An end-of-event strobe sampled at clock edge k makes the lowest road address valid after edge k+1. Roads then follow in strictly ascending address order, one per accepted transfer.
- R7: While `road_valid` is high and `road_ready` is low, `road_valid` stays high and `road_addr` holds its value.
- R8: `in_ready` is low from the edge after the end-of-event strobe until every road has been transferred. All match flags are cleared before `in_ready` returns high, so no hit of one event contributes to a road of the next.
- R9: After reset, `in_ready` is 1 and `road_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Pattern write strobe |
| ld_bank | input | 1 | Bank select: 0 direct, 1 shifted |
| ld_addr | input | AW | Pattern address |
| ld_layer | input | LW | Layer of the written entry |
| ld_ss | input | SS_W | Superstrip value written |
| hit_valid | input | 1 | Hit present this cycle |
| hit_layer | input | LW | Logical layer of the hit |
| hit_pos | input | POS_W | Fine position of the hit |
| evt_end | input | 1 | End-of-event strobe |
| in_ready | output | 1 | Hits and end-of-event are accepted |
| road_valid | output | 1 | A road address is offered |
| road_ready | input | 1 | Consumer takes the offered road |
| road_addr | output | AW | Address of the offered road |

## Verification
A hit sampled at one edge sets its flag at that edge. An end-of-event strobe sampled at edge k moves the controller into a latch cycle, so the road list is captured at edge k+1 and the first road is visible just after it. Each further road follows one edge after each accepted transfer, and `in_ready` returns one edge after the last transfer. The bench drives and samples on the falling clock edge. It checks `in_ready` low at the first falling edge after the strobe, and checks the latency with the first sample after edge k+1. It then collects roads at each later falling edge until `in_ready` rises, and compares them in order against a bench model of both banks and their coincidence.

// File: rtl/am_pkg.sv
package am_pkg;
   typedef enum logic [1:0] {
      ST_ACCEPT = 2'd0,
      ST_LATCH  = 2'd1,
      ST_DRAIN  = 2'd2
   } am_state_e;
endpackage

// File: rtl/am_ss_map.sv
module am_ss_map #(
   parameter int POS_W    = 8,
   parameter int SS_SHIFT = 2,
   parameter bit SHIFTED  = 1'b0,
   localparam int SS_W    = POS_W - SS_SHIFT
) (
   input  logic [POS_W-1:0] pos,
   output logic [SS_W-1:0]  ss,
   output logic             ok
);
   logic [SS_W-1:0] coarse;
   assign coarse = pos[POS_W-1:SS_SHIFT];

   generate
      if (SHIFTED) begin : g_shift
         // bin edges moved by half a superstrip: low half belongs to the bin below
         assign ss = pos[SS_SHIFT-1] ? coarse : coarse - 1'b1;
         assign ok = pos[SS_SHIFT-1] | (|coarse);
      end else begin : g_direct
         assign ss = coarse;
         assign ok = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/am_bank.sv
module am_bank #(
   parameter int N_LAYERS   = 11,
   parameter int N_PATT     = 16,
   parameter int POS_W      = 8,
   parameter int SS_SHIFT   = 2,
   parameter bit SHIFTED    = 1'b0,
   parameter int MISS_ALLOW = 0,
   localparam int LW        = $clog2(N_LAYERS),
   localparam int AW        = $clog2(N_PATT),
   localparam int SS_W      = POS_W - SS_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [LW-1:0]     wr_layer,
   input  logic [SS_W-1:0]   wr_ss,
   input  logic              hit_en,
   input  logic [LW-1:0]     hit_layer,
   input  logic [POS_W-1:0]  hit_pos,
   input  logic              clr,
   output logic [N_PATT-1:0] matched
);
   logic [N_LAYERS-1:0][SS_W-1:0] mem [N_PATT];
   logic [N_PATT-1:0][N_LAYERS-1:0] flg;
   logic [SS_W-1:0] map_ss;
   logic            map_ok;

   am_ss_map #(.POS_W(POS_W), .SS_SHIFT(SS_SHIFT), .SHIFTED(SHIFTED)) u_map (
      .pos (hit_pos),
      .ss  (map_ss),
      .ok  (map_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int p = 0; p < N_PATT; p++) mem[p] <= '0;
         flg <= '0;
      end else begin
         if (wr_en && (int'(wr_layer) < N_LAYERS))
            mem[wr_addr][wr_layer] <= wr_ss;
         if (clr) begin
            flg <= '0;
         end else if (hit_en && map_ok && (int'(hit_layer) < N_LAYERS)) begin
            for (int p = 0; p < N_PATT; p++)
               if (mem[p][hit_layer] == map_ss) flg[p][hit_layer] <= 1'b1;
         end
      end
   end

   generate
      for (genvar p = 0; p < N_PATT; p++) begin : g_pat
         assign matched[p] = ($countones(flg[p]) + MISS_ALLOW) >= N_LAYERS;
      end
   endgenerate

   // R2: flags move only on an accepted hit or the event clear
   a_r2_flags_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit_en && !clr) |=> $stable(flg));
endmodule

// File: rtl/am_road_sel.sv
module am_road_sel #(
   parameter int N_PATT = 16,
   localparam int AW    = $clog2(N_PATT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [N_PATT-1:0] load_mask,
   input  logic              ready,
   output logic              valid,
   output logic [AW-1:0]     addr,
   output logic              empty
);
   logic [N_PATT-1:0] pend;

   always_comb begin
      addr = '0;
      for (int i = N_PATT - 1; i >= 0; i--)
         if (pend[i]) addr = AW'(i);
   end

   assign valid = |pend;
   assign empty = ~valid;

   always_ff @(posedge clk) begin
      if (!rst_n)              pend <= '0;
      else if (load)           pend <= load_mask;
      else if (valid && ready) pend[addr] <= 1'b0;
   end

   // R6: each following road has a higher address
   a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && ready) |=> (!valid || (addr > $past(addr))));
   // R7: an offered road holds under back-pressure
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> (valid && $stable(addr)));
endmodule

// File: rtl/am_road_finder.sv
module am_road_finder #(
   parameter int N_LAYERS   = 11,
   parameter int N_PATT     = 16,
   parameter int POS_W      = 8,
   parameter int SS_SHIFT   = 2,
   parameter int MISS_ALLOW = 0,
   localparam int LW        = $clog2(N_LAYERS),
   localparam int AW        = $clog2(N_PATT),
   localparam int SS_W      = POS_W - SS_SHIFT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic             ld_bank,
   input  logic [AW-1:0]    ld_addr,
   input  logic [LW-1:0]    ld_layer,
   input  logic [SS_W-1:0]  ld_ss,
   input  logic             hit_valid,
   input  logic [LW-1:0]    hit_layer,
   input  logic [POS_W-1:0] hit_pos,
   input  logic             evt_end,
   output logic             in_ready,
   output logic             road_valid,
   input  logic             road_ready,
   output logic [AW-1:0]    road_addr
);
   import am_pkg::*;

   generate
      if (SS_SHIFT < 1) begin : g_bad_shift
         $error("SS_SHIFT must leave a half-bin bit");
      end
      if (SS_SHIFT >= POS_W) begin : g_bad_pos
         $error("POS_W must exceed SS_SHIFT");
      end
      if ((MISS_ALLOW < 0) || (MISS_ALLOW >= N_LAYERS)) begin : g_bad_miss
         $error("MISS_ALLOW out of range");
      end
      if (N_PATT != (1 << AW)) begin : g_bad_patt
         $error("N_PATT must be a power of two");
      end
   endgenerate

   am_state_e st;
   logic [1:0][N_PATT-1:0] bank_hit;
   logic hit_en, clr, load, sel_empty;

   assign in_ready = (st == ST_ACCEPT);
   assign hit_en   = hit_valid && in_ready;
   assign load     = (st == ST_LATCH);
   assign clr      = (st == ST_DRAIN) && sel_empty;

   always_ff @(posedge clk) begin
      if (!rst_n) st <= ST_ACCEPT;
      else begin
         unique case (st)
            ST_ACCEPT: if (evt_end) st <= ST_LATCH;
            ST_LATCH:  st <= ST_DRAIN;
            ST_DRAIN:  if (sel_empty) st <= ST_ACCEPT;
            default:   st <= ST_ACCEPT;
         endcase
      end
   end

   generate
      for (genvar g = 0; g < 2; g++) begin : g_bank
         am_bank #(
            .N_LAYERS(N_LAYERS), .N_PATT(N_PATT), .POS_W(POS_W),
            .SS_SHIFT(SS_SHIFT), .SHIFTED(g == 1), .MISS_ALLOW(MISS_ALLOW)
         ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (ld_en && (ld_bank == 1'(g))),
            .wr_addr   (ld_addr),
            .wr_layer  (ld_layer),
            .wr_ss     (ld_ss),
            .hit_en    (hit_en),
            .hit_layer (hit_layer),
            .hit_pos   (hit_pos),
            .clr       (clr),
            .matched   (bank_hit[g])
         );
      end
   endgenerate

   am_road_sel #(.N_PATT(N_PATT)) u_sel (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_mask (bank_hit[0] & bank_hit[1]),
      .ready     (road_ready),
      .valid     (road_valid),
      .addr      (road_addr),
      .empty     (sel_empty)
   );

   // R4: an offered road is matched in both banks
   a_r4_coincide: assert property (@(posedge clk) disable iff (!rst_n)
      road_valid |-> (bank_hit[0][road_addr] && bank_hit[1][road_addr]));
   // R8: no road is offered while hits are being accepted
   a_r8_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
      road_valid |-> !in_ready);
   // R8: input reopens only once the road list is exhausted
   a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> !road_valid);
endmodule

// File: tb/am_road_finder_test.sv
module am_road_finder_test;
   localparam int NL = 11;
   localparam int NP = 16;
   localparam int PW = 8;
   localparam int SH = 2;
   localparam int NONE = 15;

   // vector: {track1[3:0], track2[3:0] (15 = none), half bit, dropped layer[3:0] (15 = none)}
   localparam logic [12:0] VEC [8] = '{
      {4'd2,  4'd15, 1'b1, 4'd15},
      {4'd3,  4'd15, 1'b1, 4'd15},
      {4'd3,  4'd15, 1'b0, 4'd15},
      {4'd4,  4'd8,  1'b1, 4'd15},
      {4'd9,  4'd5,  1'b0, 4'd15},
      {4'd6,  4'd15, 1'b1, 4'd7},
      {4'd10, 4'd15, 1'b0, 4'd15},
      {4'd12, 4'd1,  1'b1, 4'd15}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ld_en = 1'b0, ld_bank = 1'b0;
   logic [3:0] ld_addr = '0, ld_layer = '0, hit_layer = '0;
   logic [5:0] ld_ss = '0;
   logic hit_valid = 1'b0, evt_end = 1'b0, road_ready = 1'b1;
   logic [PW-1:0] hit_pos = '0;
   logic in_ready, road_valid;
   logic [3:0] road_addr;

   int checks = 0, fails = 0, cyc = 0;
   int mA [NP][NL];
   int mB [NP][NL];
   int ev_l [64];
   int ev_p [64];
   int ev_n;
   int got [32];
   int ngot;
   logic first_valid;

   always #4 clk = ~clk;

   am_road_finder uut (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_bank(ld_bank), .ld_addr(ld_addr),
      .ld_layer(ld_layer), .ld_ss(ld_ss), .hit_valid(hit_valid), .hit_layer(hit_layer),
      .hit_pos(hit_pos), .evt_end(evt_end), .in_ready(in_ready), .road_valid(road_valid),
      .road_ready(road_ready), .road_addr(road_addr)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 60000) begin
         fails = fails + 1;
         $display("FAIL watchdog: run hung, actual %0d cycles expected < 60000", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic load(input int b, input int p, input int l, input int ss);
      @(negedge clk);
      ld_en = 1'b1; ld_bank = 1'(b); ld_addr = 4'(p); ld_layer = 4'(l); ld_ss = 6'(ss);
      if (b == 0) mA[p][l] = ss % 64; else mB[p][l] = ss % 64;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic add_track(input int t, input int h, input int drop);
      for (int l = 0; l < NL; l++)
         if (l != drop) begin
            ev_l[ev_n] = l;
            ev_p[ev_n] = (mA[t][l] << SH) | (h << (SH - 1));
            ev_n++;
         end
   endtask

   // model of both banks and their coincidence (R2, R3, R4, R5)
   function automatic logic [NP-1:0] exp_mask();
      logic [NP-1:0] m = '0;
      for (int p = 0; p < NP; p++) begin
         bit all_a = 1, all_b = 1;
         for (int l = 0; l < NL; l++) begin
            bit fa = 0, fb = 0;
            for (int k = 0; k < ev_n; k++)
               if (ev_l[k] == l) begin
                  int a = ev_p[k] >> SH;
                  int hb = (ev_p[k] >> (SH - 1)) & 1;
                  if (a == mA[p][l]) fa = 1;
                  if (hb == 1 && a == mB[p][l]) fb = 1;
                  if (hb == 0 && a != 0 && (a - 1) == mB[p][l]) fb = 1;
               end
            if (!fa) all_a = 0;
            if (!fb) all_b = 0;
         end
         m[p] = all_a && all_b;
      end
      return m;
   endfunction

   task automatic send_hits();
      for (int k = 0; k < ev_n; k++) begin
         @(negedge clk);
         hit_valid = 1'b1; hit_layer = 4'(ev_l[k]); hit_pos = PW'(ev_p[k]);
      end
   endtask

   task automatic end_event();
      @(negedge clk);
      hit_valid = 1'b0; evt_end = 1'b1;
      @(negedge clk);
      evt_end = 1'b0;
      check("R8 in_ready low after end-of-event", int'(in_ready), 0);
   endtask

   task automatic collect();
      ngot = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         if (i == 0) first_valid = road_valid;
         if (road_valid && road_ready) begin
            got[ngot] = int'(road_addr);
            ngot++;
         end
         if (in_ready) break;
      end
   endtask

   task automatic compare(input string req);
      logic [NP-1:0] m = exp_mask();
      int k = 0;
      check({req, " R6 first road latency"}, int'(first_valid), int'(m != '0));
      for (int p = 0; p < NP; p++)
         if (m[p]) begin
            check({req, " R6 road address in order"}, (k < ngot) ? got[k] : -1, p);
            k++;
         end
      check({req, " road count"}, ngot, k);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R9 in_ready after reset", int'(in_ready), 1);
      check("R9 road_valid after reset", int'(road_valid), 0);

      // R1: fill both banks; shifted copy stores bin-1 for odd patterns
      for (int p = 0; p < NP; p++)
         for (int l = 0; l < NL; l++) begin
            load(0, p, l, (3 * p + l) % 64);
            load(1, p, l, (p % 2 == 1) ? ((3 * p + l) % 64) - 1 : (3 * p + l) % 64);
         end

      // table walk: R2 R3 R4 R5 R6
      for (int v = 0; v < 8; v++) begin
         ev_n = 0;
         add_track(int'(VEC[v][12:9]), int'(VEC[v][4]), int'(VEC[v][3:0]));
         if (int'(VEC[v][8:5]) != NONE)
            add_track(int'(VEC[v][8:5]), int'(VEC[v][4]), NONE);
         send_hits();
         end_event();
         collect();
         compare($sformatf("vector %0d R2 R3 R4 R5", v));
      end

      // R7: back-pressure keeps the first road on offer
      ev_n = 0;
      add_track(4, 1, NONE);
      add_track(8, 1, NONE);
      send_hits();
      road_ready = 1'b0;
      end_event();
      @(negedge clk);
      check("R7 valid under back-pressure", int'(road_valid), 1);
      check("R7 first address", int'(road_addr), 4);
      repeat (3) @(negedge clk);
      check("R7 valid still held", int'(road_valid), 1);
      check("R7 address still held", int'(road_addr), 4);
      road_ready = 1'b1;
      @(negedge clk);
      check("R7 next address after release", int'(road_addr), 8);
      collect();

      // R8: flags of a partial event do not survive into the next one
      ev_n = 0;
      add_track(2, 1, 10);
      send_hits();
      end_event();
      collect();
      check("R8 partial event gives no road", ngot, 0);
      ev_n = 0;
      ev_l[0] = 10; ev_p[0] = (mA[2][10] << SH) | 2; ev_n = 1;
      send_hits();
      end_event();
      collect();
      check("R8 no road from stale flags", ngot, 0);
      check("R8 in_ready back", int'(in_ready), 1);

      // R3: bin 0 low half has no shifted-bank superstrip
      for (int l = 0; l < NL; l++) begin
         load(0, 15, l, 0);
         load(1, 15, l, 63);
      end
      ev_n = 0;
      for (int l = 0; l < NL; l++) begin ev_l[ev_n] = l; ev_p[ev_n] = 0; ev_n++; end
      send_hits();
      end_event();
      collect();
      compare("R3 wrap at bin 0");

      // R1: overwrite pattern 14 and find it
      for (int l = 0; l < NL; l++) begin
         load(0, 14, l, 5);
         load(1, 14, l, 5);
      end
      ev_n = 0;
      for (int l = 0; l < NL; l++) begin ev_l[ev_n] = l; ev_p[ev_n] = (5 << SH) | 2; ev_n++; end
      send_hits();
      end_event();
      collect();
      compare("R1 rewritten pattern");
      check("R1 rewritten pattern address", (ngot > 0) ? got[0] : -1, 14);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end
endmodule